// File: doc/BRIEF.md
# Boot-Time Data Bus Isolation Controller

This block sits between the data pins of a small 8-bit CPU and the shared system data bus. When a boot event occurs, it disconnects the CPU from the system bus and returns the byte 0x00 on every read instead. The CPU decodes 0x00 as a no-operation, so its program counter climbs steadily through the address space. The system address decoder still sees those fetch addresses. When the chip select of the chosen boot ROM fires on an opcode fetch, the block reconnects the bus in that same cycle, and the CPU takes its first real instruction from that ROM. Wiring the select to a ROM at 0x8000 gives one boot layout; wiring it to a ROM at 0xE000 gives another.

The parameter `USE_NMI` selects the boot trigger. With `USE_NMI = 0`, the trigger is the reset input. With `USE_NMI = 1`, the reset input leaves the bus connected, and each falling edge of the non-maskable interrupt starts a boot instead. This lets a DRAM system reboot without stopping its refresh cycles. In that mode a pulse generator holds the bus isolated for `PULSE_CYCLES` clocks after the edge.

The controller is a three-state machine:
- **LINKED**: the bus is connected.
- **PULSE**: a boot pulse is active and the bus is isolated.
- **SWEEP**: the bus is isolated and the block is waiting for the ROM strobe.

The transitions are:
- **boot_reset**: reset enters SWEEP in reset mode, or LINKED in NMI mode.
- **pulse_start**: LINKED or SWEEP moves to PULSE when the boot pulse rises.
- **pulse_end**: PULSE moves to SWEEP once the boot pulse has ended.
- **rom_hit**: SWEEP moves to LINKED on a qualifying strobe.

Top module: `boot_isolator`

## Requirements
- R1: With `USE_NMI = 0`, while reset is low and after it is released, `bus_en` is 0 and `cpu_data` is 0x00, whatever value `sys_data` carries.
- R2: While isolated, any cycle in which one or more of `romsel_n`, `mreq_n`, `rd_n`, `m1_n` is high keeps `bus_en` at 0 and `cpu_data` at 0x00, in that cycle and the next.
- R3: A cycle with `romsel_n`, `mreq_n`, `rd_n` and `m1_n` all low, in the SWEEP state, sets `bus_en` to 1 and `cpu_data` to `sys_data` in that same cycle.
- R4: Once reconnected in reset mode, the bus stays connected and `cpu_data` follows `sys_data` until the next reset.
- R5: With a sweeping address and the ROM select decoded for 0x8000 to 0xEFFF, a reset-mode boot reconnects first at address 0x8000, and reads 0x00 at every earlier address.
- R6: With `USE_NMI = 1`, reset leaves the bus connected (`bus_en` = 1, `cpu_data` = `sys_data`).
- R7: With `USE_NMI = 1`, a falling edge on `nmi_n` isolates the bus from the next cycle onward, for exactly `PULSE_CYCLES + 1` cycles, even if qualifying strobes are present. A qualifying strobe in the cycle after that reconnects the bus.
- R8: When `nmi_n` is held low, it produces a single boot only. After reconnection the bus stays connected while `nmi_n` remains low.
- R9: With `USE_NMI = 0`, `nmi_n` has no effect: a connected bus stays connected through an NMI edge.
- R10: In NMI mode, a sweep starting at 0x0066, with the ROM select decoded at 0xE000 and above, reconnects first at address 0xE000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; one CPU bus cycle per clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_n | input | 1 | Active-low non-maskable interrupt; its falling edge is the boot trigger in NMI mode |
| romsel_n | input | 1 | Active-low select of the boot ROM |
| mreq_n | input | 1 | Active-low memory request from the CPU |
| rd_n | input | 1 | Active-low read strobe from the CPU |
| m1_n | input | 1 | Active-low opcode-fetch marker from the CPU |
| sys_data | input | DATA_W | Data on the system bus |
| bus_en | output | 1 | 1 when the CPU is connected to the system bus |
| cpu_data | output | DATA_W | Byte presented to the CPU: `sys_data` when connected, 0x00 when isolated |

## Verification
The checker assumes that the CPU strobes and the ROM select are synchronous to `clk` and stay steady across each sampling edge. It also assumes that a rising `bus_en` can only be caused by a complete fetch strobe. The bench drives every input at the falling edge and holds it for the whole cycle. It raises `nmi_n` only between boots, so each boot pulse begins from a clean high level. The ROM select is asserted only at addresses the modelled decoder maps to the boot ROM.

// File: rtl/boot_iso_pkg.sv
package boot_iso_pkg;
    typedef enum logic [1:0] {
        ST_LINKED = 2'd0,
        ST_PULSE  = 2'd1,
        ST_SWEEP  = 2'd2
    } iso_state_e;
endpackage

// File: rtl/boot_nmi_pulse.sv
module boot_nmi_pulse #(
    parameter int PULSE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n,
    output logic pulse
);
    localparam int CNT_W = $clog2(PULSE_CYCLES + 1);

    logic             nmi_q;
    logic [CNT_W-1:0] cnt;
    logic             fall;

    // falling edge: previous sample high, current sample low
    assign fall  = nmi_q & ~nmi_n;
    assign pulse = (cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_q <= 1'b1;
            cnt   <= '0;
        end else begin
            nmi_q <= nmi_n;
            if (fall && cnt == '0) begin
                cnt <= CNT_W'(PULSE_CYCLES);
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/boot_release_detect.sv
module boot_release_detect (
    input  logic romsel_n,
    input  logic mreq_n,
    input  logic rd_n,
    input  logic m1_n,
    output logic hit
);
    // opcode fetch from memory with the boot ROM selected
    assign hit = ~romsel_n & ~mreq_n & ~rd_n & ~m1_n;
endmodule

// File: rtl/boot_data_gate.sv
module boot_data_gate #(
    parameter int DATA_W = 8
) (
    input  logic              pass,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign dout[i] = din[i] & pass;
    end
endmodule

// File: rtl/boot_isolator.sv
module boot_isolator
    import boot_iso_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter bit USE_NMI      = 1'b0,
    parameter int PULSE_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_n,
    input  logic              romsel_n,
    input  logic              mreq_n,
    input  logic              rd_n,
    input  logic              m1_n,
    input  logic [DATA_W-1:0] sys_data,
    output logic              bus_en,
    output logic [DATA_W-1:0] cpu_data
);
    localparam iso_state_e RESET_STATE = USE_NMI ? ST_LINKED : ST_SWEEP;

    iso_state_e state, state_nx;
    logic       raw_pulse;
    logic       nmi_pulse;
    logic       hit;

    boot_nmi_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .nmi_n (nmi_n),
        .pulse (raw_pulse)
    );

    assign nmi_pulse = raw_pulse & USE_NMI;

    boot_release_detect u_detect (
        .romsel_n (romsel_n),
        .mreq_n   (mreq_n),
        .rd_n     (rd_n),
        .m1_n     (m1_n),
        .hit      (hit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RESET_STATE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LINKED: if (nmi_pulse) state_nx = ST_PULSE;
            ST_PULSE:  if (!nmi_pulse) state_nx = ST_SWEEP;
            ST_SWEEP: begin
                if (nmi_pulse)  state_nx = ST_PULSE;
                else if (hit)   state_nx = ST_LINKED;
            end
            default:            state_nx = RESET_STATE;
        endcase
    end

    // outputs: reconnect in the cycle of the qualifying fetch
    always_comb begin
        bus_en = 1'b0;
        unique case (state)
            ST_LINKED: bus_en = ~nmi_pulse;
            ST_PULSE:  bus_en = 1'b0;
            ST_SWEEP:  bus_en = hit & ~nmi_pulse;
            default:   bus_en = 1'b0;
        endcase
    end

    boot_data_gate #(.DATA_W(DATA_W)) u_gate (
        .pass (bus_en),
        .din  (sys_data),
        .dout (cpu_data)
    );
endmodule

// File: rtl/boot_isolator_chk.sv
module boot_isolator_chk #(
    parameter bit USE_NMI = 1'b0
) (
    input logic clk,
    input logic rst_n,
    input logic nmi_n,
    input logic romsel_n,
    input logic mreq_n,
    input logic rd_n,
    input logic m1_n,
    input logic bus_en,
    input logic nmi_pulse
);
    // R3: reconnection only ever comes with a full opcode fetch from the boot ROM
    a_r3_rise_needs_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_en) |-> (!romsel_n && !mreq_n && !rd_n && !m1_n));

    // R4: in reset mode a connected bus stays connected
    a_r4_hold_link: assert property (@(posedge clk) disable iff (!rst_n)
        (!USE_NMI && bus_en) |=> bus_en);

    // R7: boot pulse always isolates the bus
    a_r7_pulse_isolates: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pulse |-> !bus_en);

    // R8: a pulse only starts after nmi_n was seen low
    a_r8_pulse_from_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_pulse) |-> !$past(nmi_n));
endmodule

bind boot_isolator boot_isolator_chk #(.USE_NMI(USE_NMI)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .nmi_n     (nmi_n),
    .romsel_n  (romsel_n),
    .mreq_n    (mreq_n),
    .rd_n      (rd_n),
    .m1_n      (m1_n),
    .bus_en    (bus_en),
    .nmi_pulse (nmi_pulse)
);

// File: tb/sim_boot_isolator.sv
module sim_boot_isolator;
    localparam int P = 4;

    logic       clk = 1'b0;
    logic       rst_n, nmi_n, mreq_n, rd_n, m1_n, romsel0_n, romsel1_n;
    logic [7:0] sys_data;
    logic       bus_en0, bus_en1;
    logic [7:0] cpu_data0, cpu_data1;
    int         checks = 0;
    int         failures = 0;

    always #10 clk = ~clk;

    boot_isolator #(.DATA_W(8), .USE_NMI(1'b0), .PULSE_CYCLES(P)) u0 (
        .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .romsel_n(romsel0_n),
        .mreq_n(mreq_n), .rd_n(rd_n), .m1_n(m1_n), .sys_data(sys_data),
        .bus_en(bus_en0), .cpu_data(cpu_data0));

    boot_isolator #(.DATA_W(8), .USE_NMI(1'b1), .PULSE_CYCLES(P)) u1 (
        .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .romsel_n(romsel1_n),
        .mreq_n(mreq_n), .rd_n(rd_n), .m1_n(m1_n), .sys_data(sys_data),
        .bus_en(bus_en1), .cpu_data(cpu_data1));

    // {romsel_n, mreq_n, rd_n, m1_n, expect_release}
    localparam logic [4:0] VEC [8] = '{
        5'b0000_1, 5'b1000_0, 5'b0100_0, 5'b0010_0,
        5'b0001_0, 5'b1111_0, 5'b0011_0, 5'b1110_0
    };

    function automatic logic [7:0] romdat(input logic [15:0] a);
        return a[7:0] ^ 8'hC3;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        romsel0_n = 1'b1; romsel1_n = 1'b1;
        mreq_n = 1'b1; rd_n = 1'b1; m1_n = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; idle();
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(20 * 190000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] addr;
        logic [15:0] first;
        logic [7:0]  got;
        bit          found, zero_bad, r9_bad;
        int          iso;

        rst_n = 1'b0; nmi_n = 1'b1; sys_data = 8'h5A; idle();
        @(negedge clk); #5;
        chk("R1 bus_en in reset", bus_en0, 0);
        chk("R1 data in reset", cpu_data0, 8'h00);
        chk("R6 nmi-mode bus_en in reset", bus_en1, 1);
        chk("R6 nmi-mode data in reset", cpu_data1, 8'h5A);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #5;
        chk("R1 bus_en after reset", bus_en0, 0);
        chk("R1 data after reset", cpu_data0, 8'h00);
        chk("R6 nmi-mode bus_en after reset", bus_en1, 1);

        // R2 / R3 / R4: strobe combinations from the isolated state
        foreach (VEC[i]) begin
            do_reset();
            @(negedge clk);
            {romsel0_n, mreq_n, rd_n, m1_n} = VEC[i][4:1];
            sys_data = 8'h3D;
            #5;
            chk($sformatf("R3/R2 vec%0d bus_en", i), bus_en0, VEC[i][0]);
            chk($sformatf("R3/R2 vec%0d data", i), cpu_data0, VEC[i][0] ? 8'h3D : 8'h00);
            @(negedge clk); idle(); sys_data = 8'hA6; #5;
            chk($sformatf("R4/R2 vec%0d next bus_en", i), bus_en0, VEC[i][0]);
            chk($sformatf("R4/R2 vec%0d next data", i), cpu_data0, VEC[i][0] ? 8'hA6 : 8'h00);
        end

        // R5: reset-mode sweep to the ROM at 0x8000
        do_reset();
        addr = 16'h0000; found = 0; zero_bad = 0; first = 16'hFFFF; got = 8'h00;
        while (!found && addr != 16'hFFFF) begin
            @(negedge clk);
            mreq_n = 1'b0; rd_n = 1'b0; m1_n = 1'b0;
            sys_data = romdat(addr);
            romsel0_n = !(addr >= 16'h8000 && addr < 16'hF000);
            #5;
            if (bus_en0) begin found = 1; first = addr; got = cpu_data0; end
            else begin
                if (cpu_data0 !== 8'h00) zero_bad = 1;
                addr++;
            end
        end
        chk("R5 first connected address", first, 16'h8000);
        chk("R5 boot opcode from ROM", got, romdat(16'h8000));
        chk("R5 zero bytes before boot", zero_bad, 0);

        // R7 / R9: NMI pulse with strobes held qualifying
        @(negedge clk); idle(); #5;
        @(negedge clk);
        nmi_n = 1'b0; sys_data = 8'h77;
        romsel1_n = 1'b0; mreq_n = 1'b0; rd_n = 1'b0; m1_n = 1'b0;
        #5;
        chk("R7 edge cycle still linked", bus_en1, 1);
        iso = 0; r9_bad = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); #5;
            if (bus_en0 !== 1'b1) r9_bad = 1;
            if (bus_en1) break;
            iso++;
        end
        chk("R7 isolated cycle count", iso, P + 1);
        chk("R7 release data", cpu_data1, 8'h77);
        chk("R9 reset-mode ignores nmi", r9_bad, 0);

        // R8: nmi_n kept low, no second boot
        @(negedge clk); idle(); #5;
        chk("R8 held nmi stays linked", bus_en1, 1);
        repeat (P + 3) @(negedge clk);
        #5;
        chk("R8 held nmi still linked", bus_en1, 1);
        chk("R8 held nmi data", cpu_data1, 8'h77);
        @(negedge clk); nmi_n = 1'b1;
        repeat (2) @(negedge clk);

        // R10: NMI-mode sweep from 0x0066 to the ROM at 0xE000
        addr = 16'h0066; found = 0; zero_bad = 0; first = 16'hFFFF; got = 8'h00;
        nmi_n = 1'b0;
        while (!found && addr != 16'hFFFF) begin
            mreq_n = 1'b0; rd_n = 1'b0; m1_n = 1'b0;
            sys_data = romdat(addr);
            romsel1_n = !(addr >= 16'hE000);
            #5;
            if (addr != 16'h0066 && bus_en1) begin found = 1; first = addr; got = cpu_data1; end
            else begin
                if (addr != 16'h0066 && cpu_data1 !== 8'h00) zero_bad = 1;
                addr++;
                @(negedge clk);
            end
        end
        chk("R10 first connected address", first, 16'hE000);
        chk("R10 boot opcode from ROM", got, romdat(16'hE000));
        chk("R10 zero bytes before boot", zero_bad, 0);
        chk("R9 reset-mode bus still linked", bus_en0, 1);

        finish_run();
    end
endmodule